// File: doc/BRIEF.md
# Two-Wire Register Access Port

This block is the serial front end of a timekeeping device. It listens on a two-wire bus (a clock line and an open-drain data line), answers to one fixed 7-bit device address, and gives a bus master byte access to a 17-location register space numbered 00h to 10h. Locations 00h to 0Fh belong to the timekeeping core and are reached through a simple read/write port. Location 10h, the backup-cell charger setting, is held inside this block.

Both bus lines are oversampled in the system clock domain. The block finds START, repeated START and STOP conditions, shifts bytes in and out MSB first, acknowledges bytes and keeps an auto-incrementing register pointer. It emits a snapshot strobe that tells the core when to copy live time into its user-visible buffers. While the main supply is flagged invalid, the block answers no transfers and changes no register. It does not stretch the clock and does not take 10-bit addresses.

Top module: `i2c_regport`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 7'b1101000. On a mismatch it leaves the data line released for the rest of the transfer, up to the next START, and writes nothing.
- R2: In a write transfer (address bit 0 = 0), the first data byte loads the pointer. A value above 10h loads 00h. Each later byte is acknowledged, stored at the pointer, and the pointer then advances.
- R3: A data write is committed as the block begins driving the acknowledge of that byte. It is already visible in the core before the master sends STOP.
- R4: In a read transfer (address bit 0 = 1), bytes are sent MSB first, starting at the current pointer. That is the last pointer left by an earlier access. The pointer advances after every byte sent. The transfer ends when the master does not acknowledge.
- R5: The pointer wraps from 10h to 00h, in reads and in writes. Writes to the core port only ever use addresses 00h to 0Fh.
- R6: The snapshot strobe is a single-cycle pulse on every START (repeated START included), on every STOP, and each time the pointer wraps to 00h.
- R7: A write of a pointer byte, then a repeated START with a read address, returns data from that pointer.
- R8: While the power-valid input is low, the block acknowledges nothing and writes nothing.
- R9: The charger register at 10h resets to 00h. A write whose bits 7..4 are 4'b1010 is kept as written and turns the charger enable on. Any other write stores 00h, which reads back as disabled.
- R10: The data-line drive changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| pwrValid | input | 1 | High while the main supply is above its fail level |
| sdaOe | output | 1 | When high, the data line is pulled low |
| regAddr | output | 5 | Register pointer presented to the core |
| regWrData | output | 8 | Byte to write to the core |
| regWrEn | output | 1 | One-cycle write strobe to the core |
| regRdData | input | 8 | Core byte at regAddr |
| snapStrobe | output | 1 | Pulse telling the core to refresh its user buffers |
| trickleCfg | output | 8 | Held charger setting (location 10h) |
| chargeEn | output | 1 | Charger enabled |

## Verification
Writes with pointer bytes scattered across the space, including values above 10h, separate pointer loading from data storage. Bursts that cross 10h show whether the wrap, the charger register and the snapshot pulse count line up. Current-address reads following writes, and random reads through a repeated START, separate pointer retention from pointer loading. Wrong addresses, power-invalid transfers and charger patterns other than 1010 each show whether an ignored access left the core, the charger output and the pointer untouched.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  // strobes from the bus controller to the datapath, one cycle each
  typedef struct packed {
    logic shiftRx;   // sample data line into receive shifter
    logic loadPtr;   // load pointer from received byte
    logic wrCommit;  // store received byte at pointer, then advance
    logic loadTx;    // load transmit shifter from pointer location
    logic shiftTx;   // move next transmit bit to the top
    logic incPtr;    // advance pointer after a transmitted byte
    logic snapReq;   // START or STOP seen
  } ctl_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_IGNORE
  } bus_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  localparam int LINES = 2;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] syncLines;
  logic [LINES-1:0] prevLines;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], rawLines[g]};
    end
    assign syncLines[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevLines <= '1;
    else       prevLines <= syncLines;
  end

  assign sclS      = syncLines[0];
  assign sdaS      = syncLines[1];
  assign sclRise   = syncLines[0] & ~prevLines[0];
  assign sclFall   = ~syncLines[0] & prevLines[0];
  assign startSeen = syncLines[0] & prevLines[0] & prevLines[1] & ~syncLines[1];
  assign stopSeen  = syncLines[0] & prevLines[0] & ~prevLines[1] & syncLines[1];

endmodule

// File: rtl/i2c_link_ctrl.sv
module i2c_link_ctrl
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdaS,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startSeen,
  input  logic        stopSeen,
  input  logic        pwrValid,
  input  logic [7:0]  rxByte,
  output ctl_strobe_t strb,
  output logic        ackDrive,
  output logic        rdDrive
);

  localparam logic [3:0] BYTE_BITS = 4'd8;

  bus_state_t state;
  logic [3:0] bitCnt;
  logic       rwBit;
  logic       firstByte;
  logic       mstAck;
  logic       byteDone;

  assign byteDone = (bitCnt == BYTE_BITS);

  always_comb begin
    strb         = '0;
    strb.snapReq = startSeen | stopSeen;
    if (!startSeen && !stopSeen) begin
      if (sclRise && !byteDone && (state == ST_ADDR || state == ST_WR_DATA))
        strb.shiftRx = 1'b1;
      if (sclFall) begin
        unique case (state)
          ST_WR_DATA: if (byteDone && pwrValid) begin
            if (firstByte) strb.loadPtr  = 1'b1;
            else           strb.wrCommit = 1'b1;
          end
          ST_ADDR_ACK: if (rwBit && pwrValid) strb.loadTx = 1'b1;
          ST_RD_DATA: begin
            if (byteDone) strb.incPtr  = 1'b1;
            else          strb.shiftTx = 1'b1;
          end
          ST_RD_ACK: if (mstAck && pwrValid) strb.loadTx = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rwBit     <= 1'b0;
      firstByte <= 1'b0;
      mstAck    <= 1'b0;
      ackDrive  <= 1'b0;
      rdDrive   <= 1'b0;
    end else if (startSeen) begin
      state     <= ST_ADDR;
      bitCnt    <= '0;
      firstByte <= 1'b1;
      ackDrive  <= 1'b0;
      rdDrive   <= 1'b0;
    end else if (stopSeen) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      rdDrive  <= 1'b0;
    end else if (sclRise) begin
      unique case (state)
        ST_ADDR, ST_WR_DATA, ST_RD_DATA: if (!byteDone) bitCnt <= bitCnt + 1'b1;
        ST_RD_ACK: mstAck <= ~sdaS;
        default: ;
      endcase
    end else if (sclFall) begin
      unique case (state)
        ST_ADDR: if (byteDone) begin
          if (rxByte[7:1] == DEV_ADDR && pwrValid) begin
            state    <= ST_ADDR_ACK;
            ackDrive <= 1'b1;
            rwBit    <= rxByte[0];
          end else begin
            state <= ST_IGNORE;
          end
        end
        ST_ADDR_ACK: begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          if (!pwrValid) state <= ST_IGNORE;
          else if (rwBit) begin
            state   <= ST_RD_DATA;
            rdDrive <= 1'b1;
          end else begin
            state <= ST_WR_DATA;
          end
        end
        ST_WR_DATA: if (byteDone) begin
          if (pwrValid) begin
            state     <= ST_WR_ACK;
            ackDrive  <= 1'b1;
            firstByte <= 1'b0;
          end else begin
            state <= ST_IGNORE;
          end
        end
        ST_WR_ACK: begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          state    <= ST_WR_DATA;
        end
        ST_RD_DATA: if (byteDone) begin
          rdDrive <= 1'b0;
          state   <= ST_RD_ACK;
        end
        ST_RD_ACK: begin
          bitCnt <= '0;
          if (mstAck && pwrValid) begin
            state   <= ST_RD_DATA;
            rdDrive <= 1'b1;
          end else begin
            state <= ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_datapath.sv
module i2c_reg_datapath
  import i2c_regport_pkg::*;
#(
  parameter int         LAST_ADDR  = 16,
  parameter logic [3:0] CHARGE_KEY = 4'b1010,
  localparam int        PTR_W      = $clog2(LAST_ADDR + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strb,
  input  logic             sdaS,
  input  logic [7:0]       regRdData,
  output logic [7:0]       rxByte,
  output logic             txMsb,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regWrData,
  output logic             regWrEn,
  output logic             snapStrobe,
  output logic [7:0]       trickleCfg,
  output logic             chargeEn
);

  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST_ADDR);
  localparam logic [7:0]       LAST_B = 8'(LAST_ADDR);

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrNext;
  logic [7:0]       txShift;
  logic [7:0]       rdByte;
  logic             atLast;
  logic             wrapNow;

  assign atLast  = (ptr == LAST_P);
  assign ptrNext = atLast ? '0 : ptr + 1'b1;
  assign wrapNow = (strb.incPtr | strb.wrCommit) & atLast;
  assign rdByte  = atLast ? trickleCfg : regRdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte     <= '0;
      txShift    <= '0;
      ptr        <= '0;
      trickleCfg <= '0;
    end else begin
      if (strb.shiftRx) rxByte <= {rxByte[6:0], sdaS};
      if (strb.loadPtr)
        ptr <= (rxByte > LAST_B) ? '0 : rxByte[PTR_W-1:0];
      else if (strb.wrCommit || strb.incPtr)
        ptr <= ptrNext;
      if (strb.wrCommit && atLast)
        trickleCfg <= (rxByte[7:4] == CHARGE_KEY) ? rxByte : 8'h00;
      if (strb.loadTx)       txShift <= rdByte;
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign txMsb      = txShift[7];
  assign regAddr    = ptr;
  assign regWrData  = rxByte;
  assign regWrEn    = strb.wrCommit & ~atLast;
  assign snapStrobe = strb.snapReq | wrapNow;
  assign chargeEn   = (trickleCfg[7:4] == CHARGE_KEY);

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1101000,
  parameter int         LAST_ADDR   = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(LAST_ADDR + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             pwrValid,
  output logic             sdaOe,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regWrData,
  output logic             regWrEn,
  input  logic [7:0]       regRdData,
  output logic             snapStrobe,
  output logic [7:0]       trickleCfg,
  output logic             chargeEn
);

  ctl_strobe_t strb;
  logic sclS, sdaS, sclRise, sclFall, startSeen, stopSeen;
  logic ackDrive, rdDrive, txMsb;
  logic [7:0] rxByte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2c_link_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .pwrValid(pwrValid),
    .rxByte(rxByte), .strb(strb), .ackDrive(ackDrive), .rdDrive(rdDrive)
  );

  i2c_reg_datapath #(.LAST_ADDR(LAST_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaS(sdaS), .regRdData(regRdData),
    .rxByte(rxByte), .txMsb(txMsb), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .snapStrobe(snapStrobe), .trickleCfg(trickleCfg),
    .chargeEn(chargeEn)
  );

  // open-drain pull: acknowledge slot or a zero data bit, never unpowered
  assign sdaOe = pwrValid & (ackDrive | (rdDrive & ~txMsb));

  logic unusedScl;
  assign unusedScl = sclS;

endmodule

// File: rtl/i2c_regport_checker.sv
module i2c_regport_checker #(
  parameter int  LAST_ADDR = 16,
  localparam int PTR_W     = $clog2(LAST_ADDR + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             pwrValid,
  input logic             sdaOe,
  input logic [PTR_W-1:0] regAddr,
  input logic             regWrEn,
  input logic             snapStrobe,
  input logic [7:0]       trickleCfg
);

  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST_ADDR);

  AST_WRITE_AT_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && pwrValid) |=> (sdaOe || !pwrValid)); // R3

  AST_CORE_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regAddr < LAST_P)); // R5

  AST_SNAP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    snapStrobe |=> !snapStrobe); // R6

  AST_NO_WRITE_UNPOWERED: assert property (@(posedge clk) disable iff (!rstN)
    !pwrValid |-> !regWrEn); // R8

  AST_CHARGER_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (trickleCfg != 8'h00) |-> (trickleCfg[7:4] == 4'b1010)); // R9

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (pwrValid && $past(pwrValid) && !$stable(sdaOe)) |-> !sclIn); // R10

endmodule

bind i2c_regport i2c_regport_checker #(.LAST_ADDR(LAST_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .pwrValid(pwrValid), .sdaOe(sdaOe),
  .regAddr(regAddr), .regWrEn(regWrEn), .snapStrobe(snapStrobe),
  .trickleCfg(trickleCfg)
);

// File: tb/sim_i2c_regport.sv
module sim_i2c_regport;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [7:0] WR_ADDR = 8'hD0;
  localparam logic [7:0] RD_ADDR = 8'hD1;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1, pwrValid = 1'b1;
  logic sdaLine, sdaOe, regWrEn, snapStrobe, chargeEn;
  logic [4:0] regAddr;
  logic [7:0] regWrData, regRdData, trickleCfg;
  logic [7:0] coreMem [0:15];
  int snapCnt, wrCnt, sdaHighMoves;
  int checks = 0, fails = 0;

  logic [7:0] expMem [0:15];
  logic [7:0] expTrk;
  int expPtr;
  logic [7:0] wrBuf [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  i2c_regport u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .pwrValid(pwrValid),
    .sdaOe(sdaOe), .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdData(regRdData), .snapStrobe(snapStrobe), .trickleCfg(trickleCfg),
    .chargeEn(chargeEn)
  );

  // timekeeping core stand-in
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) coreMem[i] <= 8'h00;
    end else if (regWrEn) coreMem[regAddr[3:0]] <= regWrData;
  end
  assign regRdData = coreMem[regAddr[3:0]];

  logic prevOe;
  always @(posedge clk) begin
    if (!rstN) begin
      snapCnt <= 0; wrCnt <= 0; sdaHighMoves <= 0; prevOe <= 1'b0;
    end else begin
      prevOe <= sdaOe;
      if (snapStrobe) snapCnt <= snapCnt + 1;
      if (regWrEn) wrCnt <= wrCnt + 1;
      if (sclM && (sdaOe != prevOe)) sdaHighMoves <= sdaHighMoves + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == 16) ? 0 : p + 1;
  endfunction

  function automatic logic [7:0] trkStore(input logic [7:0] b);
    return (b[7:4] == 4'b1010) ? b : 8'h00;
  endfunction

  function automatic logic [7:0] expAt(input int p);
    return (p == 16) ? expTrk : expMem[p];
  endfunction

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitHalf();
    sclM = 1'b1; waitHalf();
    sdaM = 1'b0; waitHalf();
    sclM = 1'b0; waitHalf();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitHalf();
    sclM = 1'b1; waitHalf();
    sdaM = 1'b1; waitHalf();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitHalf();
      sclM = 1'b1; waitHalf();
      sclM = 1'b0;
    end
    sdaM = 1'b1; waitHalf();
    sclM = 1'b1; waitHalf();
    ack = ~sdaLine;
    sclM = 1'b0; waitHalf();
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitHalf();
      sclM = 1'b1; waitHalf();
      b[i] = sdaLine;
      sclM = 1'b0;
    end
    sdaM = giveAck ? 1'b0 : 1'b1; waitHalf();
    sclM = 1'b1; waitHalf();
    sclM = 1'b0; waitHalf();
    sdaM = 1'b1;
  endtask

  // write n bytes of wrBuf starting at pointer p (R2, R5, R6, R9)
  task automatic doWrite(input logic [7:0] p, input int n);
    bit ack; int snap0 = snapCnt; int wraps = 0;
    startCond();
    sendByte(WR_ADDR, ack); check(ack, "R1 address ack", ack, 1);
    sendByte(p, ack);       check(ack, "R2 pointer ack", ack, 1);
    expPtr = (p > 8'h10) ? 0 : int'(p);
    for (int k = 0; k < n; k++) begin
      sendByte(wrBuf[k], ack); check(ack, "R2 data ack", ack, 1);
      if (expPtr == 16) begin expTrk = trkStore(wrBuf[k]); wraps++; end
      else expMem[expPtr] = wrBuf[k];
      expPtr = nxt(expPtr);
    end
    stopCond();
    repeat (4) @(negedge clk);
    check(snapCnt - snap0 == 2 + wraps, "R6 snapshot count", snapCnt - snap0, 2 + wraps);
    for (int i = 0; i < 16; i++)
      if (coreMem[i] != expMem[i]) check(0, "R2 core content", coreMem[i], expMem[i]);
    check(trickleCfg == expTrk, "R9 charger register", trickleCfg, expTrk);
  endtask

  task automatic readBody(input int n, input string tag);
    logic [7:0] got;
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, got);
      check(got == expAt(expPtr), tag, got, expAt(expPtr));
      expPtr = nxt(expPtr);
    end
    stopCond();
  endtask

  task automatic doReadCur(input int n);
    bit ack;
    startCond();
    sendByte(RD_ADDR, ack); check(ack, "R4 read address ack", ack, 1);
    readBody(n, "R4 current read");
  endtask

  task automatic doRandRead(input logic [7:0] p, input int n);
    bit ack;
    startCond();
    sendByte(WR_ADDR, ack); check(ack, "R7 address ack", ack, 1);
    sendByte(p, ack);       check(ack, "R7 pointer ack", ack, 1);
    expPtr = (p > 8'h10) ? 0 : int'(p);
    startCond();
    sendByte(RD_ADDR, ack); check(ack, "R7 restart ack", ack, 1);
    readBody(n, "R7 random read");
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ack; int w0; int s0;
    void'($urandom(32'd1339));
    for (int i = 0; i < 16; i++) expMem[i] = 8'h00;
    expTrk = 8'h00; expPtr = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    check(sdaOe == 1'b0, "R1 reset released", sdaOe, 0);
    check(trickleCfg == 8'h00, "R9 reset value", trickleCfg, 0);
    check(chargeEn == 1'b0, "R9 reset disabled", chargeEn, 0);
    check(snapCnt == 0, "R6 reset no snapshot", snapCnt, 0);

    // commit visible before STOP
    startCond();
    sendByte(WR_ADDR, ack); check(ack, "R1 match ack", ack, 1);
    sendByte(8'h03, ack);
    sendByte(8'h11, ack);
    check(coreMem[3] == 8'h11, "R3 commit before stop", coreMem[3], 8'h11);
    stopCond();
    expMem[3] = 8'h11; expPtr = 4;

    doReadCur(2);
    doRandRead(8'h03, 1);

    // wrap across the charger location
    wrBuf[0] = 8'hC3; wrBuf[1] = 8'hA5; wrBuf[2] = 8'h44;
    doWrite(8'h0F, 3);
    check(chargeEn == 1'b1, "R9 key enables", chargeEn, 1);
    doRandRead(8'h10, 2);
    check(expPtr == 1, "R5 wrap in read", expPtr, 1);
    doReadCur(1);

    wrBuf[0] = 8'h5A;
    doWrite(8'h10, 1);
    check(chargeEn == 1'b0, "R9 other pattern disables", chargeEn, 0);

    wrBuf[0] = 8'h77;
    doWrite(8'h30, 1);
    check(coreMem[0] == 8'h77, "R2 oversize pointer loads 00h", coreMem[0], 8'h77);

    // wrong address
    w0 = wrCnt;
    startCond();
    sendByte(8'hA0, ack); check(!ack, "R1 mismatch no ack", ack, 0);
    sendByte(8'h02, ack); check(!ack, "R1 ignored byte no ack", ack, 0);
    sendByte(8'hEE, ack);
    stopCond();
    check(wrCnt == w0, "R1 mismatch no write", wrCnt, w0);

    // supply invalid
    pwrValid = 1'b0;
    startCond();
    sendByte(WR_ADDR, ack); check(!ack, "R8 no ack unpowered", ack, 0);
    sendByte(8'h02, ack);
    sendByte(8'hEE, ack);
    stopCond();
    pwrValid = 1'b1;
    repeat (4) @(negedge clk);
    check(wrCnt == w0, "R8 no write unpowered", wrCnt, w0);
    doRandRead(8'h02, 1);

    // random traffic
    for (int it = 0; it < 24; it++) begin
      int n = 1 + int'($urandom % 3);
      logic [7:0] p = 8'($urandom % 17);
      for (int k = 0; k < n; k++) begin
        wrBuf[k] = 8'($urandom);
        if ($urandom % 4 == 0) wrBuf[k][7:4] = 4'b1010;
      end
      s0 = snapCnt;
      case ($urandom % 3)
        0: doWrite(p, n);
        1: doRandRead(p, n);
        default: doReadCur(n);
      endcase
      check(snapCnt > s0, "R6 snapshot on transfer", snapCnt - s0, 2);
    end

    check(sdaHighMoves == 0, "R10 drive moves with SCL low", sdaHighMoves, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule